// File: doc/BRIEF.md
# Cache Miss Line-Fill Sequencer

This block sits on the cache-controller side of a synchronous processor bus. Each cycle it sees the processor's request, the nullify flag that goes with it and the hit or miss result of an outside tag lookup. On a miss it freezes the processor pipeline with a hold output and takes the shared bus with a bus-not-available output. It then asks a simple memory port for the missing line and writes each returned doubleword into the cache data array.

The memory sends the line in wrap order, starting with the doubleword the processor asked for. That first beat goes onto the bus together with a one-cycle data strobe, and hold drops in that same cycle, so the processor restarts at once. The other beats of the line are written while the processor runs, and bus ownership ends only after the last write. If the memory flags an error on a beat, a one-cycle exception pulse goes to the processor. The cache output enable follows the processor's nullify, so the cache RAM drives the bus only for requests the processor has not cancelled.

Request addresses are byte addresses. Bits [2:0] select a byte within a doubleword, bits [4:3] select the doubleword within a four-beat line, and the next `IDX_W` bits select the line in the data array.

Top module: `miss_fill_seq`

## Requirements
- R1: A request seen while the sequencer is idle, with `req_valid`=1, `req_nullify`=0 and `tag_hit`=0, starts a fill. From the next cycle `hold` and `bus_na` are both 1.
- R2: A request with `tag_hit`=1 or with `req_nullify`=1 starts no fill. `hold`, `bus_na` and `mem_req_valid` stay 0.
- R3: During a fill, `mem_req_valid` is 1 and `mem_req_addr` holds the requested address with bits [2:0] cleared. Both stay unchanged until `mem_req_ready` is sampled as 1.
- R4: The k-th accepted memory beat (k=0..3) is written one cycle after it is accepted. The write has `arr_we`=1, `arr_addr` = {line index, (requested doubleword + k) mod 4} and `bus_data` = the beat's data. No other cycle writes.
- R5: While beats are pending, `mem_rsp_ready` is 1, and any number of idle cycles between beats is accepted.
- R6: `data_strobe` is 1 for exactly one cycle per fill. That cycle is the one in which the requested doubleword (beat 0) is written and shown on `bus_data`.
- R7: `hold` stays 1 until the strobe cycle and is 0 in that cycle. It stays 0 while the rest of the line is written.
- R8: `bus_na` is 1 in every write cycle. It falls in the cycle right after the fourth write.
- R9: A beat with `mem_rsp_err`=1 gives a one-cycle `mem_exc` pulse, in the same cycle as that beat's write. Only the first such beat in a fill gives a pulse.
- R10: `cache_oe` is 0 while `req_nullify` is 1 and 1 while it is 0.
- R11: After reset, `hold`, `bus_na`, `data_strobe`, `mem_exc`, `arr_we` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_nullify | input | 1 | Processor cancels the current access |
| tag_hit | input | 1 | External tag lookup hit for this request |
| cache_oe | output | 1 | Cache RAM output enable |
| hold | output | 1 | Freeze processor pipeline |
| bus_na | output | 1 | Processor must release the shared bus |
| data_strobe | output | 1 | Requested doubleword valid on bus_data |
| mem_exc | output | 1 | One-cycle memory exception pulse |
| bus_data | output | DATA_W | Data placed on the shared bus |
| arr_we | output | 1 | Cache data array write enable |
| arr_addr | output | IDX_W+2 | Data array address {index, doubleword} |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Doubleword-aligned critical address |
| mem_rsp_valid | input | 1 | Memory beat present |
| mem_rsp_ready | output | 1 | Sequencer accepts a beat |
| mem_rsp_data | input | DATA_W | Beat data |
| mem_rsp_err | input | 1 | Beat carries a memory error |

## Verification
If the beat counter or the latched critical offset holds a wrong value, the next fill shows a wrong `arr_addr` on its first write. So the error can be seen one cycle after the first beat is accepted. A wrong FSM state shows up as `bus_na` falling too early or too late around the fourth write, or as `mem_rsp_ready` being missing when a beat arrives. In both cases the fill stops or the bus is released before the line is complete. If the hold flag or the error-seen flag is wrong, the strobe cycle shows `hold` still high, or a second or missing `mem_exc` pulse appears, within the same fill.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_FILL = 2'd2,
      ST_LAST = 2'd3
   } mfs_state_e;
endpackage

// File: rtl/mfs_beat_ctr.sv
// Counts accepted beats of one line and forms the wrapped doubleword offset.
module mfs_beat_ctr #(
   parameter int BEATS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     advance,
   input  logic [$clog2(BEATS)-1:0] crit_off,
   output logic [$clog2(BEATS)-1:0] off,
   output logic                     is_first,
   output logic                     is_last
);
   localparam int BW = $clog2(BEATS);
   localparam logic [BW-1:0] LAST_CNT = BW'(BEATS - 1);

   logic [BW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clear)    cnt_q <= '0;
      else if (advance)  cnt_q <= cnt_q + 1'b1;
   end

   generate
      if ((BEATS & (BEATS - 1)) == 0) begin : g_pow2
         // power-of-two line: modular add wraps naturally
         assign off = crit_off + cnt_q;
      end else begin : g_mod
         logic [BW:0] sum;
         assign sum = {1'b0, crit_off} + {1'b0, cnt_q};
         assign off = (sum >= (BW+1)'(BEATS)) ? BW'(sum - (BW+1)'(BEATS)) : sum[BW-1:0];
      end
   endgenerate

   assign is_first = (cnt_q == '0);
   assign is_last  = (cnt_q == LAST_CNT);
endmodule

// File: rtl/mfs_fsm.sv
// Fill sequencing: idle -> request -> receive beats -> final write cycle.
module mfs_fsm
   import mfs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       req_acc,
   input  logic       beat_acc,
   input  logic       last_beat,
   output mfs_state_e state
);
   mfs_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (start)                  nxt = ST_REQ;
         ST_REQ:  if (req_acc)                nxt = ST_FILL;
         ST_FILL: if (beat_acc && last_beat)  nxt = ST_LAST;
         ST_LAST:                             nxt = ST_IDLE;
         default:                             nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/miss_fill_seq.sv
// Cache miss line-fill sequencer with critical-word forwarding.
module miss_fill_seq
   import mfs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int BEATS  = 4,
   parameter int IDX_W  = 6
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               req_valid,
   input  logic [ADDR_W-1:0]                  req_addr,
   input  logic                               req_nullify,
   input  logic                               tag_hit,
   output logic                               cache_oe,
   output logic                               hold,
   output logic                               bus_na,
   output logic                               data_strobe,
   output logic                               mem_exc,
   output logic [DATA_W-1:0]                  bus_data,
   output logic                               arr_we,
   output logic [IDX_W+$clog2(BEATS)-1:0]     arr_addr,
   output logic                               mem_req_valid,
   input  logic                               mem_req_ready,
   output logic [ADDR_W-1:0]                  mem_req_addr,
   input  logic                               mem_rsp_valid,
   output logic                               mem_rsp_ready,
   input  logic [DATA_W-1:0]                  mem_rsp_data,
   input  logic                               mem_rsp_err
);
   localparam int BEAT_W  = $clog2(BEATS);
   localparam int BYTE_W  = $clog2(DATA_W / 8);
   localparam int ARR_W   = IDX_W + BEAT_W;
   localparam int IDX_LSB = BYTE_W + BEAT_W;
   localparam int HI_W    = ADDR_W - BYTE_W;

   generate
      if (BEATS < 2) begin : g_bad_beats
         $error("miss_fill_seq: BEATS must be at least 2");
      end
      if ((DATA_W % 8) != 0 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("miss_fill_seq: DATA_W must be a power of two byte multiple");
      end
      if (IDX_LSB + IDX_W > ADDR_W) begin : g_bad_idx
         $error("miss_fill_seq: index field does not fit in the address");
      end
   endgenerate

   mfs_state_e        state;
   logic              start, req_acc, beat_acc;
   logic [HI_W-1:0]   crit_hi;
   logic [IDX_W-1:0]  line_idx;
   logic [BEAT_W-1:0] crit_off, beat_off;
   logic              first_beat, last_beat;
   logic              hold_q, strobe_q, exc_q, we_q, err_seen_q;
   logic [DATA_W-1:0] data_q;
   logic [ARR_W-1:0]  aaddr_q;

   assign start    = (state == ST_IDLE) & req_valid & ~req_nullify & ~tag_hit;
   assign req_acc  = mem_req_valid & mem_req_ready;
   assign beat_acc = mem_rsp_ready & mem_rsp_valid;

   // critical doubleword address latched at the start of a fill
   always_ff @(posedge clk) begin
      if (!rst_n)     crit_hi <= '0;
      else if (start) crit_hi <= req_addr[ADDR_W-1:BYTE_W];
   end

   assign crit_off = crit_hi[BEAT_W-1:0];
   assign line_idx = crit_hi[BEAT_W +: IDX_W];

   mfs_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .req_acc   (req_acc),
      .beat_acc  (beat_acc),
      .last_beat (last_beat),
      .state     (state)
   );

   mfs_beat_ctr #(.BEATS(BEATS)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .advance  (beat_acc),
      .crit_off (crit_off),
      .off      (beat_off),
      .is_first (first_beat),
      .is_last  (last_beat)
   );

   // registered bus side: write, forward, release hold, flag errors
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q     <= 1'b0;
         strobe_q   <= 1'b0;
         exc_q      <= 1'b0;
         we_q       <= 1'b0;
         err_seen_q <= 1'b0;
         data_q     <= '0;
         aaddr_q    <= '0;
      end else begin
         we_q     <= beat_acc;
         strobe_q <= beat_acc & first_beat;
         exc_q    <= beat_acc & mem_rsp_err & ~err_seen_q;
         if (start)                       hold_q <= 1'b1;
         else if (beat_acc && first_beat) hold_q <= 1'b0;
         if (start)                       err_seen_q <= 1'b0;
         else if (beat_acc && mem_rsp_err) err_seen_q <= 1'b1;
         if (beat_acc) begin
            data_q  <= mem_rsp_data;
            aaddr_q <= {line_idx, beat_off};
         end
      end
   end

   assign hold          = hold_q;
   assign bus_na        = (state != ST_IDLE);
   assign data_strobe   = strobe_q;
   assign mem_exc       = exc_q;
   assign arr_we        = we_q;
   assign arr_addr      = aaddr_q;
   assign bus_data      = data_q;
   assign mem_req_valid = (state == ST_REQ);
   assign mem_req_addr  = {crit_hi, {BYTE_W{1'b0}}};
   assign mem_rsp_ready = (state == ST_FILL);
   assign cache_oe      = ~req_nullify;
endmodule

// File: rtl/miss_fill_seq_chk.sv
// Temporal properties of the fill sequencer, bound onto every instance.
module miss_fill_seq_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold,
   input logic              bus_na,
   input logic              data_strobe,
   input logic              mem_exc,
   input logic              arr_we,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr
);
   // R1: a held processor never owns the bus
   a_r1_hold_has_bus: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> bus_na);

   // R3: pending memory request keeps valid and address
   a_r3_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R6: strobe lasts one cycle and rides on a write
   a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      data_strobe |=> !data_strobe);
   a_r6_strobe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      data_strobe |-> arr_we);

   // R7: hold falls exactly as the strobe rises
   a_r7_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
      data_strobe |-> $fell(hold));

   // R8: array writes only while the bus is taken
   a_r8_write_owns_bus: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> bus_na);

   // R9: exception is a single-cycle pulse aligned to a write
   a_r9_exc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_exc |=> !mem_exc);
   a_r9_exc_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_exc |-> arr_we);
endmodule

bind miss_fill_seq miss_fill_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .hold          (hold),
   .bus_na        (bus_na),
   .data_strobe   (data_strobe),
   .mem_exc       (mem_exc),
   .arr_we        (arr_we),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr)
);

// File: tb/sim_miss_fill_seq.sv
`timescale 1ns/1ps
module sim_miss_fill_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_nullify = 1'b0;
   logic        tag_hit = 1'b0;
   logic        cache_oe, hold, bus_na, data_strobe, mem_exc, arr_we;
   logic [63:0] bus_data;
   logic [7:0]  arr_addr;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic        mem_rsp_ready;
   logic [63:0] mem_rsp_data = '0;
   logic        mem_rsp_err = 1'b0;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   miss_fill_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_nullify(req_nullify), .tag_hit(tag_hit), .cache_oe(cache_oe),
      .hold(hold), .bus_na(bus_na), .data_strobe(data_strobe), .mem_exc(mem_exc),
      .bus_data(bus_data), .arr_we(arr_we), .arr_addr(arr_addr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
      .mem_rsp_err(mem_rsp_err)
   );

   typedef struct {
      logic [7:0]  aa;
      logic [63:0] d;
      logic        st;
      logic        ex;
   } exp_t;
   exp_t sb[$];

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] pat(input logic [31:0] a);
      return {a, a ^ 32'h5A3C_0000};
   endfunction

   // monitor: pops expected writes from the scoreboard
   logic prev_hold = 1'b0;
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n) begin
         if (arr_we) begin
            if (sb.size() == 0) chk(1'b0, "R4 unexpected write", 64'(arr_addr), 64'hX);
            else begin
               e = sb.pop_front();
               chk(arr_addr == e.aa, "R4 array address", 64'(arr_addr), 64'(e.aa));
               chk(bus_data == e.d, "R4 write data", bus_data, e.d);
               chk(data_strobe == e.st, "R6 strobe on beat", 64'(data_strobe), 64'(e.st));
               chk(mem_exc == e.ex, "R9 exception pulse", 64'(mem_exc), 64'(e.ex));
            end
            chk(bus_na, "R8 bus_na during write", 64'(bus_na), 64'd1);
         end else if (data_strobe || mem_exc) begin
            chk(1'b0, "R6/R9 strobe or exc without write", {62'd0, data_strobe, mem_exc}, 64'd0);
         end
         if (data_strobe)
            chk(!hold && prev_hold, "R7 hold falls with strobe", {62'd0, prev_hold, hold}, 64'b10);
      end
      prev_hold = hold;
   end

   // driver plus memory stub for one miss
   task automatic do_miss(input logic [31:0] a, input int gap, input int rdly, input logic [3:0] emask);
      logic [1:0]  crit = a[4:3];
      logic [31:0] base = {a[31:5], 5'b0};
      int          first_err = -1;
      for (int k = 0; k < 4; k++)
         if (emask[k] && first_err < 0) first_err = k;
      for (int k = 0; k < 4; k++) begin
         exp_t e;
         logic [1:0] off = crit + 2'(k);
         e.aa = {a[10:5], off};
         e.d  = pat(base + 32'(off) * 8);
         e.st = (k == 0);
         e.ex = (k == first_err);
         sb.push_back(e);
      end
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; tag_hit = 1'b0; req_nullify = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(hold, "R1 hold raised", 64'(hold), 64'd1);
      chk(bus_na, "R1 bus_na raised", 64'(bus_na), 64'd1);
      chk(mem_req_valid, "R3 request valid", 64'(mem_req_valid), 64'd1);
      chk(mem_req_addr == {a[31:3], 3'b0}, "R3 request address", 64'(mem_req_addr), 64'({a[31:3], 3'b0}));
      for (int i = 0; i < rdly; i++) begin
         @(negedge clk);
         chk(mem_req_valid && mem_req_addr == {a[31:3], 3'b0}, "R3 request held",
             64'(mem_req_addr), 64'({a[31:3], 3'b0}));
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int k = 0; k < 4; k++) begin
         logic [1:0] off = crit + 2'(k);
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(hold == (k == 0), "R7 hold level while line fills", 64'(hold), 64'(k == 0));
         end
         chk(mem_rsp_ready, "R5 ready for beat", 64'(mem_rsp_ready), 64'd1);
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = pat(base + 32'(off) * 8);
         mem_rsp_err   = emask[k];
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         mem_rsp_err   = 1'b0;
      end
      chk(bus_na, "R8 bus_na in last write", 64'(bus_na), 64'd1);
      @(negedge clk);
      chk(!bus_na, "R8 bus_na released", 64'(bus_na), 64'd0);
      chk(sb.size() == 0, "R4 all beats written", 64'(sb.size()), 64'd0);
      @(negedge clk);
   endtask

   task automatic no_fill(input logic hit, input logic nul, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0000_0468; tag_hit = hit; req_nullify = nul;
      @(negedge clk);
      req_valid = 1'b0; tag_hit = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk(!hold && !bus_na && !mem_req_valid, tag, {61'd0, hold, bus_na, mem_req_valid}, 64'd0);
         @(negedge clk);
      end
      req_nullify = 1'b0;
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!hold && !bus_na && !data_strobe && !mem_exc && !arr_we && !mem_req_valid,
          "R11 reset outputs", {58'd0, hold, bus_na, data_strobe, mem_exc, arr_we, mem_req_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: output enable follows nullify
      req_nullify = 1'b1; #1;
      chk(!cache_oe, "R10 oe low on nullify", 64'(cache_oe), 64'd0);
      req_nullify = 1'b0; #1;
      chk(cache_oe, "R10 oe high after nullify", 64'(cache_oe), 64'd1);
      // R2: hit and nullified requests ignored
      no_fill(1'b1, 1'b0, "R2 hit starts no fill");
      no_fill(1'b0, 1'b1, "R2 nullified request starts no fill");
      // R4/R5/R6: fills with different critical words, gaps and delays
      do_miss(32'h0000_0000, 0, 0, 4'b0000);
      do_miss(32'h0000_1238, 2, 3, 4'b0000);
      do_miss(32'h0000_0F50, 1, 1, 4'b0110);   // R9 first error only
      do_miss(32'hABCD_E7CC, 3, 0, 4'b1000);   // R9 error on final beat
      do_miss(32'h0000_0448, 0, 2, 4'b0001);   // R9 error on critical beat
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule